// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between an asynchronous byte-wide memory bus and the write engine of a flash controller. The bus has an active-low chip select, an active-low write strobe, an address and a data byte. At the end of each write strobe the block captures the address and the data and treats the data byte as a command. It tracks two-write sequences: program setup followed by the program data, and erase setup followed by a confirm. It keeps the pointer that decides whether reads return array contents, the identifier bytes or the status register.

Toward the write engine it issues single-cycle requests to program, erase, suspend and resume. The engine reports back with a completion pulse and a suspend-acknowledge pulse. While the engine is working or is suspended, only a small set of commands is accepted and every other command is dropped. Malformed erase sequences raise the two sequence-error status bits together, and a clear-status command lowers them.

Top module: `flash_cmd_fsm`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_sel` is 0 (array), both error bits are low, and no request pulses are issued.
- R2: Each write strobe causes exactly one command action. A write strobe is the interval in which `bus_ce_n` and `bus_we_n` are both low, and it ends when either one goes high. The action completes within 4 clock edges of the end of the strobe, using the address and data present on the bus at that time.
- R3: When the engine is idle, 0xFF sets `rd_sel` to 0 (array), 0x90 sets it to 1 (identifier), and 0x70, 0x40 and 0x20 set it to 2 (status).
- R4: `id_byte` is MFR_ID (0x89) when `bus_addr` bit 0 is 0 and DEV_ID (0x7C) when it is 1. The other address bits have no effect.
- R5: The write that follows 0x40 is taken as program data, whatever its value. It produces one `req_program` pulse, loads `prog_addr` and `prog_data`, and leaves `rd_sel` at 2.
- R6: 0x20 followed by 0xD0 produces one `req_erase` pulse, loads `prog_addr` with the block address, and leaves `rd_sel` at 2.
- R7: 0x20 followed by any byte other than 0xD0 sets both `err_prog` and `err_erase`, sets `rd_sel` to 2, and issues no erase request.
- R8: A 0xD0 that neither follows 0x20 nor arrives during a suspend sets both error bits and issues no request.
- R9: 0x50 clears both error bits.
- R10: While a program is running, only 0x70 is accepted. Every other byte, including 0x40 followed by data, is ignored until `eng_done` is seen.
- R11: While an erase is running, 0xB0 produces one `req_suspend` pulse and 0x70 is accepted. All other bytes are ignored, and 0xD0 is also ignored until the suspend is requested.
- R12: After a suspend is requested, 0xD0 produces one `req_resume` pulse and sets `rd_sel` to 2. Once `eng_susp_ack` has been seen, 0xFF (array reads) is also accepted. Other bytes, such as 0x90, are ignored.
- R13: 0xB0 while idle and any reserved code (0x00 or any byte not listed) change nothing. After `eng_done`, `rd_sel` stays at 2 until a new command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_we_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_addr | input | AW | Bus address |
| bus_data | input | 8 | Bus write data / command byte |
| eng_done | input | 1 | Write engine finished its operation (pulse) |
| eng_susp_ack | input | 1 | Write engine reached its suspended state (pulse) |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_byte | output | 8 | Identifier byte selected by address bit 0 |
| req_program | output | 1 | Start-program pulse |
| req_erase | output | 1 | Start-erase pulse |
| req_suspend | output | 1 | Suspend-erase pulse |
| req_resume | output | 1 | Resume-erase pulse |
| prog_addr | output | AW | Latched program or erase address |
| prog_data | output | 8 | Latched program data |
| err_prog | output | 1 | Sequence error, program status bit |
| err_erase | output | 1 | Sequence error, erase status bit |

## Verification
The release of a strobe passes through a two-stage synchronizer and an edge register. The captured command is registered, and the sequencer acts on the following edge, so `rd_sel`, the error bits and the latched address and data settle by the fourth rising edge after the release. The bench drives each write and then waits eight falling edges before it samples, which keeps every check past that point. Request pulses last one cycle, so the bench counts them at every rising edge and compares the change in count over each command. `id_byte` is registered one edge after the address changes and is sampled two edges later. Sweeps over all 256 command bytes, first from the idle array state and then as the byte after an erase setup, set the expected values from the command table.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [2:0] {
    M_ARRAY, M_IDENT, M_STATUS, M_PSETUP, M_ESETUP
  } mode_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PROG, PH_ERASE, PH_SWAIT, PH_SUSP
  } phase_t;

  typedef enum logic [3:0] {
    C_RDARR, C_IDENT, C_RDSTAT, C_CLRSTAT, C_PSETUP,
    C_ESETUP, C_SUSP, C_CONF, C_RSVD
  } cmd_t;

  localparam logic [1:0] RS_ARRAY  = 2'd0;
  localparam logic [1:0] RS_IDENT  = 2'd1;
  localparam logic [1:0] RS_STATUS = 2'd2;

endpackage

// File: rtl/fc_cmd_decode.sv
module fc_cmd_decode
  import fc_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       kind
);
  always_comb begin
    case (code)
      8'hFF:   kind = C_RDARR;
      8'h90:   kind = C_IDENT;
      8'h70:   kind = C_RDSTAT;
      8'h50:   kind = C_CLRSTAT;
      8'h40:   kind = C_PSETUP;
      8'h20:   kind = C_ESETUP;
      8'hB0:   kind = C_SUSP;
      8'hD0:   kind = C_CONF;
      default: kind = C_RSVD;
    endcase
  end
endmodule

// File: rtl/fc_strobe_sync.sv
module fc_strobe_sync #(
  parameter int AW    = 18,
  parameter int DW    = 8,
  parameter int NSYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          cmd_vld,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic [NSYNC:0] sh;
  logic           wr_act;
  logic           wr_end;

  assign wr_act = ~ce_n & ~we_n;

  genvar g;
  generate
    for (g = 0; g <= NSYNC; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= wr_act;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sh[g] <= 1'b0;
          else     sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  assign wr_end = sh[NSYNC] & ~sh[NSYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd_vld <= wr_end;
      if (wr_end) begin
        cmd_addr <= addr_in;
        cmd_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/fc_mode_fsm.sv
module fc_mode_fsm
  import fc_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_vld,
  input  cmd_t          cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          eng_done,
  input  logic          eng_susp_ack,
  output logic [1:0]    rd_sel,
  output logic          req_program,
  output logic          req_erase,
  output logic          req_suspend,
  output logic          req_resume,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          err_prog,
  output logic          err_erase
);
  mode_t  mode_q, mode_d;
  phase_t ph_q, ph_d;
  logic   errs_set, errs_clr;
  logic   st_prog, st_erase, st_susp, st_res;

  always_comb begin
    mode_d   = mode_q;
    ph_d     = ph_q;
    errs_set = 1'b0;
    errs_clr = 1'b0;
    st_prog  = 1'b0;
    st_erase = 1'b0;
    st_susp  = 1'b0;
    st_res   = 1'b0;

    // engine feedback
    if (eng_done && ph_q != PH_IDLE) ph_d = PH_IDLE;
    else if (eng_susp_ack && ph_q == PH_SWAIT) ph_d = PH_SUSP;

    if (cmd_vld) begin
      unique case (ph_q)
        PH_PROG: begin
          if (cmd_kind == C_RDSTAT) mode_d = M_STATUS;
        end
        PH_ERASE: begin
          if (cmd_kind == C_RDSTAT) mode_d = M_STATUS;
          else if (cmd_kind == C_SUSP && !eng_done) begin
            st_susp = 1'b1;
            ph_d    = PH_SWAIT;
          end
        end
        PH_SWAIT, PH_SUSP: begin
          if (cmd_kind == C_RDSTAT) mode_d = M_STATUS;
          else if (cmd_kind == C_RDARR && ph_q == PH_SUSP) mode_d = M_ARRAY;
          else if (cmd_kind == C_CONF && !eng_done) begin
            st_res = 1'b1;
            ph_d   = PH_ERASE;
            mode_d = M_STATUS;
          end
        end
        default: begin
          if (mode_q == M_PSETUP) begin
            st_prog = 1'b1;
            ph_d    = PH_PROG;
            mode_d  = M_STATUS;
          end else if (mode_q == M_ESETUP) begin
            mode_d = M_STATUS;
            if (cmd_kind == C_CONF) begin
              st_erase = 1'b1;
              ph_d     = PH_ERASE;
            end else begin
              errs_set = 1'b1;
            end
          end else begin
            unique case (cmd_kind)
              C_RDARR:   mode_d = M_ARRAY;
              C_IDENT:   mode_d = M_IDENT;
              C_RDSTAT:  mode_d = M_STATUS;
              C_CLRSTAT: errs_clr = 1'b1;
              C_PSETUP:  mode_d = M_PSETUP;
              C_ESETUP:  mode_d = M_ESETUP;
              C_CONF:    errs_set = 1'b1;
              default:   ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_ARRAY;
      ph_q        <= PH_IDLE;
      rd_sel      <= RS_ARRAY;
      req_program <= 1'b0;
      req_erase   <= 1'b0;
      req_suspend <= 1'b0;
      req_resume  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      err_prog    <= 1'b0;
      err_erase   <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      ph_q        <= ph_d;
      req_program <= st_prog;
      req_erase   <= st_erase;
      req_suspend <= st_susp;
      req_resume  <= st_res;
      unique case (mode_d)
        M_ARRAY: rd_sel <= RS_ARRAY;
        M_IDENT: rd_sel <= RS_IDENT;
        default: rd_sel <= RS_STATUS;
      endcase
      if (st_prog || st_erase) prog_addr <= cmd_addr;
      if (st_prog) prog_data <= cmd_data;
      if (errs_set) begin
        err_prog  <= 1'b1;
        err_erase <= 1'b1;
      end else if (errs_clr) begin
        err_prog  <= 1'b0;
        err_erase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fc_pkg::*;
#(
  parameter int          AW     = 18,
  parameter int          NSYNC  = 2,
  parameter logic [7:0]  MFR_ID = 8'h89,
  parameter logic [7:0]  DEV_ID = 8'h7C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_data,
  input  logic          eng_done,
  input  logic          eng_susp_ack,
  output logic [1:0]    rd_sel,
  output logic [7:0]    id_byte,
  output logic          req_program,
  output logic          req_erase,
  output logic          req_suspend,
  output logic          req_resume,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          err_prog,
  output logic          err_erase
);
  localparam int DW = 8;

  logic          cmd_vld;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  cmd_t          cmd_kind;

  fc_strobe_sync #(.AW(AW), .DW(DW), .NSYNC(NSYNC)) u_sync (
    .clk(clk), .rst(rst), .ce_n(bus_ce_n), .we_n(bus_we_n),
    .addr_in(bus_addr), .data_in(bus_data),
    .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fc_cmd_decode u_dec (.code(cmd_data), .kind(cmd_kind));

  fc_mode_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .eng_done(eng_done), .eng_susp_ack(eng_susp_ack),
    .rd_sel(rd_sel), .req_program(req_program), .req_erase(req_erase),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .err_prog(err_prog), .err_erase(err_erase)
  );

  always_ff @(posedge clk) begin
    if (rst) id_byte <= MFR_ID;
    else     id_byte <= bus_addr[0] ? DEV_ID : MFR_ID;
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_vld,
  input logic [1:0] rd_sel,
  input logic       req_program,
  input logic       req_erase,
  input logic       req_suspend,
  input logic       req_resume,
  input logic       err_prog,
  input logic       err_erase
);
  // R2: one strobe end gives a single-cycle command pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> !cmd_vld);

  // R5: requests toward the engine never overlap
  p_req_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_program, req_erase, req_suspend, req_resume}));

  // R5: a program start leaves reads on the status register
  p_prog_status_r5: assert property (@(posedge clk) disable iff (rst)
    req_program |-> rd_sel == 2'd2);

  // R6: an erase start leaves reads on the status register
  p_erase_status_r6: assert property (@(posedge clk) disable iff (rst)
    req_erase |-> rd_sel == 2'd2);

  // R7: both error bits rise together
  p_err_pair_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_prog) |-> err_erase);

  // R9: both error bits fall together
  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(err_erase) |-> !err_prog);

  // R12: a resume returns reads to status
  p_resume_status_r12: assert property (@(posedge clk) disable iff (rst)
    req_resume |-> rd_sel == 2'd2);
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk chk_i (
  .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .rd_sel(rd_sel),
  .req_program(req_program), .req_erase(req_erase),
  .req_suspend(req_suspend), .req_resume(req_resume),
  .err_prog(err_prog), .err_erase(err_erase)
);

// File: tb/flash_cmd_fsm_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_ce_n = 1'b1;
  logic          bus_we_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_data = '0;
  logic          eng_done = 1'b0;
  logic          eng_susp_ack = 1'b0;
  logic [1:0]    rd_sel;
  logic [7:0]    id_byte;
  logic          req_program, req_erase, req_suspend, req_resume;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          err_prog, err_erase;

  int n_chk = 0;
  int n_bad = 0;
  int c_prog = 0, c_erase = 0, c_susp = 0, c_res = 0;
  int b_prog, b_erase, b_susp, b_res;

  always #10 clk = ~clk;

  flash_cmd_fsm #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .eng_done(eng_done), .eng_susp_ack(eng_susp_ack),
    .rd_sel(rd_sel), .id_byte(id_byte),
    .req_program(req_program), .req_erase(req_erase),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .err_prog(err_prog), .err_erase(err_erase)
  );

  always @(posedge clk) begin
    if (req_program) c_prog  <= c_prog + 1;
    if (req_erase)   c_erase <= c_erase + 1;
    if (req_suspend) c_susp  <= c_susp + 1;
    if (req_resume)  c_res   <= c_res + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic mark();
    b_prog = c_prog; b_erase = c_erase; b_susp = c_susp; b_res = c_res;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_data = d;
    bus_ce_n = 1'b0; bus_we_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_we_n = 1'b1; bus_ce_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); eng_susp_ack = 1'b1;
    @(negedge clk); eng_susp_ack = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int exp_sel(input logic [7:0] c);
    case (c)
      8'hFF: return 0;
      8'h90: return 1;
      8'h70, 8'h40, 8'h20: return 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rd_sel in reset", rd_sel, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_sel after reset", rd_sel, 0);
    chk("R1 errors after reset", {err_prog, err_erase}, 0);
    chk("R1 no requests", c_prog + c_erase + c_susp + c_res, 0);

    // R4 identifier
    wr('0, 8'h90);
    chk("R3 identifier select", rd_sel, 1);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); bus_addr = AW'(a * 32771);
      repeat (2) @(negedge clk);
      chk("R4 id byte", id_byte, (a * 32771) % 2 == 1 ? 8'h7C : 8'h89);
    end

    // sweep: every code from idle array mode (R3, R8, R13, R2)
    for (int c = 0; c < 256; c++) begin
      wr('0, 8'h50);
      wr('0, 8'hFF);
      mark();
      wr(AW'(c * 7), 8'(c));
      chk("R3 sweep rd_sel", rd_sel, exp_sel(8'(c)));
      chk("R8 sweep errors", {err_prog, err_erase}, c == 8'hD0 ? 3 : 0);
      chk("R13 sweep no request",
          (c_prog - b_prog) + (c_erase - b_erase) + (c_susp - b_susp) + (c_res - b_res), 0);
      if (c == 8'h40) begin
        wr('0, 8'h00);
        chk("R2 one program per strobe", c_prog - b_prog, 1);
        done_pulse();
      end else if (c == 8'h20) begin
        wr('0, 8'hFF);
      end
    end

    // sweep: every byte after erase setup (R6, R7)
    for (int c = 0; c < 256; c++) begin
      wr('0, 8'h50);
      wr('0, 8'hFF);
      wr(AW'(c * 5), 8'h20);
      mark();
      wr(AW'(c * 5), 8'(c));
      chk("R7 setup rd_sel", rd_sel, 2);
      if (c == 8'hD0) begin
        chk("R6 erase req", c_erase - b_erase, 1);
        chk("R6 erase addr", prog_addr, (c * 5) % (1 << AW));
        chk("R6 no errors", {err_prog, err_erase}, 0);
        done_pulse();
      end else begin
        chk("R7 no erase req", c_erase - b_erase, 0);
        chk("R7 both errors", {err_prog, err_erase}, 3);
      end
    end
    wr('0, 8'h50);
    chk("R9 clear errors", {err_prog, err_erase}, 0);

    // program with busy gating
    wr('0, 8'hFF);
    mark();
    wr('0, 8'h40);
    chk("R3 program setup status", rd_sel, 2);
    wr(18'h2A5A5, 8'hFF);
    chk("R5 program req", c_prog - b_prog, 1);
    chk("R5 program addr", prog_addr, 18'h2A5A5);
    chk("R5 program data", prog_data, 8'hFF);
    chk("R5 program rd_sel", rd_sel, 2);
    wr('0, 8'hFF);
    chk("R10 read array ignored", rd_sel, 2);
    wr('0, 8'h90);
    chk("R10 identifier ignored", rd_sel, 2);
    wr('0, 8'h40);
    wr(18'h00011, 8'h12);
    chk("R10 second program ignored", c_prog - b_prog, 1);
    chk("R10 data unchanged", prog_data, 8'hFF);
    wr('0, 8'hD0);
    chk("R10 confirm ignored", {err_prog, err_erase}, 0);
    done_pulse();
    chk("R13 status after done", rd_sel, 2);
    wr('0, 8'hFF);
    chk("R3 back to array", rd_sel, 0);

    // erase, suspend, resume
    mark();
    wr(18'h3C000, 8'h20);
    wr(18'h3C000, 8'hD0);
    chk("R6 erase start", c_erase - b_erase, 1);
    wr('0, 8'hD0);
    chk("R11 confirm ignored while erasing", c_res - b_res, 0);
    chk("R11 no error while erasing", {err_prog, err_erase}, 0);
    wr('0, 8'h90);
    chk("R11 identifier ignored", rd_sel, 2);
    wr('0, 8'hB0);
    chk("R11 suspend req", c_susp - b_susp, 1);
    wr('0, 8'hFF);
    chk("R12 array ignored before ack", rd_sel, 2);
    ack_pulse();
    wr('0, 8'hFF);
    chk("R12 array while suspended", rd_sel, 0);
    wr('0, 8'h90);
    chk("R12 identifier ignored", rd_sel, 0);
    wr('0, 8'hB0);
    chk("R12 second suspend ignored", c_susp - b_susp, 1);
    wr('0, 8'hD0);
    chk("R12 resume req", c_res - b_res, 1);
    chk("R12 resume status", rd_sel, 2);
    chk("R12 no error", {err_prog, err_erase}, 0);
    done_pulse();
    wr('0, 8'hB0);
    chk("R13 idle suspend ignored", c_susp - b_susp, 1);
    chk("R13 idle status kept", rd_sel, 2);

    // R1 reset mid-sequence
    wr('0, 8'h20);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset returns array", rd_sel, 0);
    wr('0, 8'hFF);
    chk("R1 no stale erase setup", {err_prog, err_erase}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule